// File: doc/BRIEF.md
# Dual-Rail Word Receiver with Completion Detection

This block receives a word whose bits each travel on their own pair of wires, a true rail and a false rail, so an N-bit word uses 2N input wires. Every bit signals its own validity. The pair is at rest (both rails low) between words, and a bit is present once exactly one rail is high. The sender alternates data words with all-rest phases in a four-phase, return-to-rest cycle. The block tells the sender when a whole word has arrived and when the lines have all gone back to rest.

The block runs on a clock. Every input wire goes through a two-flop synchroniser. Each bit is then decoded, and a held-state completion cell watches the decoded bits. That cell rises only when every bit carries a value and falls only when every bit is back at rest. In every other case it keeps its state. The cell rising captures the word into a registered output. The acknowledge follows the cell one cycle later, in both directions, which hands the four-phase protocol back to the sender. A pair with both rails high is a coding fault: it sets a sticky error flag and can never count as a valid bit.

Top module: `dr_rx`

## Requirements
- R1: While reset is low and after it is released, `done`, `ack`, `err` and `data_out` are all zero.
- R2: Each bit i is decoded from the pair {`rail_t[i]`, `rail_f[i]`}: 00 is rest, 01 is logic 0, 10 is logic 1. The captured `data_out[i]` equals the decoded value.
- R3: `done` does not rise while any bit is at rest, however long the other bits have been valid.
- R4: When all pairs become valid before a clock edge k, `done` rises and `data_out` is loaded at edge k+2. Neither changes at edges k or k+1.
- R5: `ack` rises at the clock edge that follows the rise of `done`.
- R6: Once high, `done` stays high while some bits return to rest. It falls two edges after the edge at which the last pair reaches rest.
- R7: `ack` falls at the clock edge that follows the fall of `done`.
- R8: `data_out` keeps its captured value through the acknowledge, the rest phase and any rail activity, until the next completion.
- R9: A pair with both rails high sets `err` at the same latency as R4. `err` stays set until reset. While such a pair is present, `done` cannot rise.
- R10: A new word is accepted only after a full rest phase. A different valid word that replaces the current one without passing through rest is not captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rail_t | input | N | True rail of each bit pair |
| rail_f | input | N | False rail of each bit pair |
| data_out | output | N | Last completed word |
| done | output | 1 | Completion state: word complete, not yet returned to rest |
| ack | output | 1 | Four-phase acknowledge to the sender |
| err | output | 1 | Sticky flag for a pair with both rails high |

## Verification
The hardest states to reach from the ports are the mixed ones, where the completion cell has to hold its value. Examples are a word that is only partly valid, a word that is only partly back at rest, and a valid word swapped for another without a rest phase in between. The bench builds each of these by driving only a subset of the pairs. It keeps them there for several cycles longer than the synchroniser latency, and it checks that `done` and `data_out` do not move. The illegal-pair case is driven in the middle of an otherwise valid word. A later legal word then shows that the error stays set while the completion logic goes on working.

// File: rtl/dr_rx_pkg.sv
// Package dr_rx_pkg
// Shared encoding of one rail pair, written {true, false}, and the decoder
// used by the per-bit logic. Assumes rest is both rails low.
package dr_rx_pkg;

    typedef enum logic [1:0] {
        PAIR_REST    = 2'b00,
        PAIR_ZERO    = 2'b01,
        PAIR_ONE     = 2'b10,
        PAIR_INVALID = 2'b11
    } pair_code_e;

    typedef struct packed {
        logic valid;
        logic rest;
        logic bad;
        logic value;
    } pair_info_t;

    // Turn one rail pair into its decoded flags
    function automatic pair_info_t decode_pair(input logic t, input logic f);
        pair_info_t info;
        info = '0;
        case (pair_code_e'({t, f}))
            PAIR_REST:    info.rest  = 1'b1;
            PAIR_ZERO:    info.valid = 1'b1;
            PAIR_ONE:     begin info.valid = 1'b1; info.value = 1'b1; end
            default:      info.bad   = 1'b1;
        endcase
        return info;
    endfunction

endpackage

// File: rtl/dr_sync.sv
// Module dr_sync
// Multi-flop synchroniser for a bus of independent asynchronous wires.
// Assumes each wire is used on its own. Bits are not treated as a coherent
// group: the completion logic further on handles skew between them.
module dr_sync #(
    parameter int W     = 16,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);

    logic [W-1:0] stage_q [DEPTH];

    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First flop samples the raw wires
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= d_in;
                end
            end else begin : g_next
                // Later flops resolve metastability
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign d_out = stage_q[DEPTH-1];

endmodule

// File: rtl/dr_pair_decode.sv
// Module dr_pair_decode
// Decodes each synchronised rail pair into valid, rest, bad and value flags.
// Pure combinational logic. Assumes the inputs are already synchronised.
module dr_pair_decode
    import dr_rx_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] t_in,
    input  logic [N-1:0] f_in,
    output logic [N-1:0] valid,
    output logic [N-1:0] rest,
    output logic [N-1:0] bad,
    output logic [N-1:0] value
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            pair_info_t info;
            // Decode a single pair
            always_comb info = decode_pair(t_in[i], f_in[i]);
            assign valid[i] = info.valid;
            assign rest[i]  = info.rest;
            assign bad[i]   = info.bad;
            assign value[i] = info.value;
        end
    endgenerate

endmodule

// File: rtl/dr_completion.sv
// Module dr_completion
// Clocked model of a completion tree of held-state cells. The output rises
// when every bit is valid and falls when every bit is at rest; otherwise it
// holds. The reductions are built as a balanced pairwise tree.
// Assumes decoded flags come from one clock domain.
module dr_completion #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] valid,
    input  logic [N-1:0] rest,
    output logic         complete,
    output logic         capture
);

    localparam int LEVELS = (N > 1) ? $clog2(N) : 1;
    localparam int WIDTH  = 1 << LEVELS;

    logic [WIDTH-1:0] all_v [LEVELS+1];
    logic [WIDTH-1:0] all_r [LEVELS+1];
    logic             state_q;

    // Tree leaves; unused leaves are neutral for both reductions
    always_comb begin
        all_v[0] = '1;
        all_r[0] = '1;
        all_v[0][N-1:0] = valid;
        all_r[0][N-1:0] = rest;
    end

    generate
        for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
            for (genvar j = 0; j < (WIDTH >> (l + 1)); j++) begin : g_node
                assign all_v[l+1][j] = all_v[l][2*j] & all_v[l][2*j+1];
                assign all_r[l+1][j] = all_r[l][2*j] & all_r[l][2*j+1];
            end
            if ((WIDTH >> (l + 1)) < WIDTH) begin : g_pad
                assign all_v[l+1][WIDTH-1:(WIDTH >> (l + 1))] = '0;
                assign all_r[l+1][WIDTH-1:(WIDTH >> (l + 1))] = '0;
            end
        end
    endgenerate

    // Held-state cell: set on all valid, clear on all rest, else keep
    always_ff @(posedge clk) begin
        if (!rst_n)             state_q <= 1'b0;
        else if (all_v[LEVELS][0]) state_q <= 1'b1;
        else if (all_r[LEVELS][0]) state_q <= 1'b0;
    end

    assign complete = state_q;
    assign capture  = all_v[LEVELS][0] & ~state_q;

endmodule

// File: rtl/dr_rx.sv
// Module dr_rx
// Dual-rail word receiver. Synchronises 2N rails, decodes the pairs, detects
// word completion and return to rest, captures the word, and drives a
// four-phase acknowledge that follows completion by one cycle.
// Assumes the sender keeps to the return-to-rest protocol. Faulty pairs are
// flagged and never counted as valid.
module dr_rx #(
    parameter int N          = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] rail_t,
    input  logic [N-1:0] rail_f,
    output logic [N-1:0] data_out,
    output logic         done,
    output logic         ack,
    output logic         err
);

    localparam int BUS_W = 2 * N;

    logic [BUS_W-1:0] sync_bus;
    logic [N-1:0]     bit_valid, bit_rest, bit_bad, bit_value;
    logic             complete, capture, any_illegal;
    logic [N-1:0]     data_q;
    logic             ack_q, err_q;

    dr_sync #(.W(BUS_W), .DEPTH(SYNC_DEPTH)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({rail_t, rail_f}),
        .d_out (sync_bus)
    );

    dr_pair_decode #(.N(N)) dec_i (
        .t_in  (sync_bus[BUS_W-1:N]),
        .f_in  (sync_bus[N-1:0]),
        .valid (bit_valid),
        .rest  (bit_rest),
        .bad   (bit_bad),
        .value (bit_value)
    );

    dr_completion #(.N(N)) cmp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (bit_valid),
        .rest     (bit_rest),
        .complete (complete),
        .capture  (capture)
    );

    assign any_illegal = |bit_bad;

    // Load the word only at the moment completion is first reached
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (capture) data_q <= bit_value;
    end

    // Acknowledge trails the completion state by one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) ack_q <= 1'b0;
        else        ack_q <= complete;
    end

    // Sticky coding-fault flag
    always_ff @(posedge clk) begin
        if (!rst_n)           err_q <= 1'b0;
        else if (any_illegal) err_q <= 1'b1;
    end

    assign data_out = data_q;
    assign done     = complete;
    assign ack      = ack_q;
    assign err      = err_q;

endmodule

// File: rtl/dr_rx_chk.sv
// Module dr_rx_chk
// Protocol checker for dr_rx, attached with bind. Looks at the ports and at
// the decoded fault flag.
module dr_rx_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] data_out,
    input logic         done,
    input logic         ack,
    input logic         err,
    input logic         any_illegal
);

    AST_ACK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |=> ack); // R5
    AST_ACK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |=> !ack); // R7
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(done) |-> $stable(data_out)); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err); // R9
    AST_NO_DONE_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        (any_illegal && !done) |=> !done); // R9
    AST_REST_BEFORE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !ack); // R10

endmodule

bind dr_rx dr_rx_chk #(.N(N)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .data_out    (data_out),
    .done        (done),
    .ack         (ack),
    .err         (err),
    .any_illegal (any_illegal)
);

// File: tb/dr_rx_tb_top.sv
// Directed bench for dr_rx: one task per scenario, each checking its results.
module dr_rx_tb_top;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] rail_t = '0;
    logic [N-1:0] rail_f = '0;
    logic [N-1:0] data_out;
    logic         done, ack, err;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dr_rx #(.N(N), .SYNC_DEPTH(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .rail_t(rail_t), .rail_f(rail_f),
        .data_out(data_out), .done(done), .ack(ack), .err(err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic drive(input logic [N-1:0] t, input logic [N-1:0] f);
        @(negedge clk);
        rail_t = t;
        rail_f = f;
    endtask

    task automatic do_reset();
        drive('0, '0);
        rst_n = 1'b0;
        step(3);
        check("R1 done", done, 0);
        check("R1 ack", ack, 0);
        check("R1 err", err, 0);
        check("R1 data", data_out, 0);
        @(negedge clk);
        rst_n = 1'b1;
        step(2);
        check("R1 done after release", done, 0);
        check("R1 ack after release", ack, 0);
    endtask

    // Full handshake of one word, timing checked edge by edge
    task automatic t_word(input logic [N-1:0] val, input logic [N-1:0] prev);
        drive(val, ~val);
        step(2);
        check("R4 done not early", done, 0);
        check("R4 data not early", data_out, prev);
        step(1);
        check("R4 done rises", done, 1);
        check("R2 decoded data", data_out, val);
        check("R5 ack still low", ack, 0);
        step(1);
        check("R5 ack rises", ack, 1);
        drive('0, '0);
        step(2);
        check("R6 done holds", done, 1);
        step(1);
        check("R6 done falls", done, 0);
        check("R7 ack still high", ack, 1);
        step(1);
        check("R7 ack falls", ack, 0);
        check("R8 data held after rest", data_out, val);
    endtask

    // Partial words and word swaps without rest
    task automatic t_partial();
        drive(8'h05, 8'h0A);
        step(6);
        check("R3 partial word", done, 0);
        check("R8 data before complete", data_out, 8'h3C);
        drive(8'h65, 8'h9A);
        step(3);
        check("R3 completes", done, 1);
        check("R2 data 65", data_out, 8'h65);
        drive(8'h60, 8'h90);
        step(5);
        check("R6 partial rest holds done", done, 1);
        check("R8 data during partial rest", data_out, 8'h65);
        drive(8'h13, 8'hEC);
        step(5);
        check("R10 swap no recapture", data_out, 8'h65);
        check("R10 done stays", done, 1);
        drive('0, '0);
        step(4);
        check("R6 done after full rest", done, 0);
        check("R7 ack after full rest", ack, 0);
    endtask

    // Bad pair inside a word, then a legal word
    task automatic t_illegal();
        drive(8'h58, 8'hAF);
        step(2);
        check("R9 err not early", err, 0);
        step(1);
        check("R9 err set", err, 1);
        step(4);
        check("R9 no done on bad pair", done, 0);
        drive('0, '0);
        step(4);
        check("R9 err sticky", err, 1);
        drive(8'h81, 8'h7E);
        step(3);
        check("R9 later word completes", done, 1);
        check("R9 later word data", data_out, 8'h81);
        check("R9 err still set", err, 1);
        drive('0, '0);
        step(4);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        t_word(8'hA5, 8'h00);
        t_word(8'h00, 8'hA5);
        t_word(8'hFF, 8'h00);
        t_word(8'h3C, 8'hFF);
        t_partial();
        t_illegal();
        do_reset();
        t_word(8'h96, 8'h00);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule